// File: doc/BRIEF.md
# Word-serial Montgomery modular multiplier

This block forms the Montgomery product C = A·B·R⁻¹ mod N of multi-word operands, with R = 2^(32·s) and s the operand length in 32-bit words. The word product and the reduction product are merged into a single inner loop. Each outer iteration first derives a reduction factor m from the lowest accumulator word and the stored negative inverse n′ = −N⁻¹ mod 2³². It then sweeps the words, adding a_i·b_j and m·n_j to the accumulator while shifting it down by one word. A final carry fold closes the iteration. After the last iteration, N is subtracted once when the accumulator is not below N.

Software loads A, B, N and n′ through one word write port. It then pulses `start` with the length in words, waits for the one-cycle `done` pulse and reads the result words by address. The length is sampled at `start`, so the same datapath serves any key size from 4 to 64 words. A squaring mode computes A·A·R⁻¹ mod N. In this mode, iteration i uses a multiplicand that is zero below word i, a_i at word i and 2·a_j above it, so each cross product is formed once and doubled.

Top module: `mont_mul_fios`

## Requirements
- R1: With A < N and N odd, after `done` the result words 0..s−1 read through `rd_addr` equal A·B·2^(−32·s) mod N, fully reduced below N. A is written with `wr_sel` = 0, B with `wr_sel` = 1 and N with `wr_sel` = 2, each at word address `wr_addr`, least significant word at address 0.
- R2: The length s is taken from `len_words` when `start` is accepted and may be any value from 4 to 64. Bank words at addresses s and above have no effect on the result.
- R3: The negative inverse n′ is written with `wr_sel` = 3 (address ignored). It is held in a register and used by every later operation until it is rewritten.
- R4: With `sqr_mode` = 1 at `start`, the result is A·A·2^(−32·s) mod N. The B bank has no effect.
- R5: `busy` is high from the edge that accepts `start` until `done`. `done` is high for exactly one cycle, s²+3s clock edges after the accepting edge, and `busy` is low in that cycle.
- R6: After `done`, the result stays readable at `rd_data` until the next accepted `start`. Writes to the operand banks do not change it.
- R7: While `busy` is high, operand writes and `start` are ignored.
- R8: After reset, `busy` and `done` are low and `rd_data` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when idle) |
| sqr_mode | input | 1 | 1 selects squaring of A |
| len_words | input | 7 | Operand length in 32-bit words |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 2 | Target: 0 A, 1 B, 2 N, 3 n′ |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Word written |
| rd_addr | input | 6 | Result word address |
| rd_data | output | 32 | Result word at `rd_addr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the fold of the final carry into the two spare accumulator words. A wrong fold corrupts only the upper result words, and it shows most at 64 words and with operands of N−1. An off-by-one reduction factor leaves a nonzero low word and breaks every result. The bench checks that the Montgomery form of one times B returns B, and it compares results across odd lengths, because a fixed-length assumption fails there. In squaring mode, the B bank is filled with unrelated data. A masking error at the diagonal word therefore shows as a result that depends on B, or as cross products counted once or four times. It also writes and pulses `start` mid-run, and it rereads results after later writes, to catch banks that accept writes while busy and an output that moves after `done`.

// File: rtl/mmm_pkg.sv
// Shared types for the word-serial Montgomery multiplier.
package mmm_pkg;

    // Sequencer phases of one operation.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for start, result readable
        ST_QUOT  = 3'd1,   // derive reduction factor m for outer iteration i
        ST_MAC   = 3'd2,   // inner word sweep: product plus reduction, shifted
        ST_SHIFT = 3'd3,   // fold carry into the spare words (word division)
        ST_SUB   = 3'd4    // conditional subtraction of N, word serial
    } mmm_state_e;

endpackage

// File: rtl/mmm_opbank.sv
// Word-addressed register bank with one synchronous write port and one
// combinational read port. Assumes addresses are below DEPTH.
module mmm_opbank #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Storage update: clear on reset, otherwise write one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read port.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mmm_mac_cell.sv
// One inner-loop word step: acc + a*d + m*n + carry_in.
// d is one bit wider so that a doubled word (squaring) fits. Assumes
// CW >= WORD_W+3, which bounds the outgoing carry for these operand widths.
module mmm_mac_cell #(
    parameter int WORD_W = 32,
    parameter int CW     = WORD_W + 3,
    localparam int SW    = WORD_W + CW
) (
    input  logic [WORD_W-1:0] acc_w,
    input  logic [WORD_W-1:0] a_w,
    input  logic [WORD_W:0]   d_w,
    input  logic [WORD_W-1:0] m_w,
    input  logic [WORD_W-1:0] n_w,
    input  logic [CW-1:0]     cin,
    output logic [WORD_W-1:0] lo,
    output logic [CW-1:0]     cout
);

    logic [SW-1:0] sum;

    // Wide sum of both partial products plus accumulator and carry.
    always_comb begin
        sum = SW'(acc_w) + SW'(a_w) * SW'(d_w) + SW'(m_w) * SW'(n_w) + SW'(cin);
    end

    assign lo   = sum[WORD_W-1:0];
    assign cout = sum[SW-1:WORD_W];

endmodule

// File: rtl/mmm_sub_cell.sv
// One word of a ripple subtraction a - b - borrow_in.
module mmm_sub_cell #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a_w,
    input  logic [WORD_W-1:0] b_w,
    input  logic              bin,
    output logic [WORD_W-1:0] diff,
    output logic              bout
);

    logic [WORD_W:0] wide;

    // Subtract with one guard bit; the guard bit is the borrow out.
    always_comb begin
        wide = {1'b0, a_w} - {1'b0, b_w} - (WORD_W+1)'(bin);
    end

    assign diff = wide[WORD_W-1:0];
    assign bout = wide[WORD_W];

endmodule

// File: rtl/mont_mul_fios.sv
// Word-serial Montgomery multiplier, operand-scanning with product and
// reduction merged in one inner loop. Per outer iteration i:
//   QUOT : m = (t0 + a_i*d_0) * n' mod 2^W
//   MAC  : s cycles, t[j-1] <= low(t[j] + a_i*d_j + m*n_j + c)
//   SHIFT: fold the carry into the two spare accumulator words
// then SUB subtracts N once when the accumulator is not below N.
// Assumes A < N, N odd, n' = -N^-1 mod 2^W, and MIN_WORDS <= len <= MAX_WORDS.
module mont_mul_fios
    import mmm_pkg::*;
#(
    parameter int  WORD_W    = 32,
    parameter int  MIN_WORDS = 4,
    parameter int  MAX_WORDS = 64,
    localparam int LEN_W     = $clog2(MAX_WORDS + 1),
    localparam int IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sqr_mode,
    input  logic [LEN_W-1:0]  len_words,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    localparam int ACC_D = MAX_WORDS + 2;   // s words plus two spare words
    localparam int CW    = WORD_W + 3;      // inner-loop carry width
    localparam int NBANK = 3;               // A, B, N
    localparam int FW    = 2 * WORD_W + 1;  // carry fold width

    mmm_state_e        state_q;
    logic [LEN_W-1:0]  len_q, i_q, j_q;
    logic              sqr_q, borrow_q, use_diff_q, done_q;
    logic [WORD_W-1:0] m_q, ai_q, ninv_q;
    logic [CW-1:0]     carry_q;
    logic [WORD_W-1:0] acc_q [ACC_D];

    logic              idle;
    logic [LEN_W-1:0]  last_idx, hi0_idx, hi1_idx;
    logic              bank_we [NBANK];
    logic [IDX_W-1:0]  bank_ra [NBANK];
    logic [WORD_W-1:0] bank_rd [NBANK];
    logic [WORD_W-1:0] a_rd, b_rd, n_rd, res_rd;

    logic [WORD_W-1:0] q_d0, q_lo, q_t, m_next;
    logic [WORD_W:0]   d_w;
    logic [WORD_W-1:0] mac_lo;
    logic [CW-1:0]     mac_cout;
    logic              mac_first;
    logic [FW-1:0]     fold_val;
    logic [WORD_W-1:0] sub_diff;
    logic              sub_bout;

    assign idle     = (state_q == ST_IDLE);
    assign last_idx = len_q - LEN_W'(1);
    assign hi0_idx  = len_q;
    assign hi1_idx  = len_q + LEN_W'(1);

    // Operand banks A, B, N: written only while idle; A is read at word i
    // during QUOT and at word j otherwise.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign bank_we[g] = wr_en && idle && (wr_sel == 2'(g));
        assign bank_ra[g] = (g == 0 && state_q == ST_QUOT) ? i_q[IDX_W-1:0]
                                                            : j_q[IDX_W-1:0];
        mmm_opbank #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (bank_ra[g]),
            .rdata (bank_rd[g])
        );
    end

    assign a_rd = bank_rd[0];
    assign b_rd = bank_rd[1];
    assign n_rd = bank_rd[2];

    // Reduction factor for the coming outer iteration (j is 0 here).
    always_comb begin
        if (!sqr_q)          q_d0 = b_rd;
        else if (i_q == '0)  q_d0 = a_rd;
        else                 q_d0 = '0;
        q_lo   = a_rd * q_d0;
        q_t    = acc_q[0] + q_lo;
        m_next = q_t * ninv_q;
    end

    // Multiplicand word: B, or in squaring 0 / a_i / 2*a_j by position.
    always_comb begin
        if (!sqr_q)          d_w = {1'b0, b_rd};
        else if (j_q < i_q)  d_w = '0;
        else if (j_q == i_q) d_w = {1'b0, ai_q};
        else                 d_w = {a_rd, 1'b0};
    end

    mmm_mac_cell #(.WORD_W(WORD_W), .CW(CW)) u_mac (
        .acc_w (acc_q[j_q]),
        .a_w   (ai_q),
        .d_w   (d_w),
        .m_w   (m_q),
        .n_w   (n_rd),
        .cin   (carry_q),
        .lo    (mac_lo),
        .cout  (mac_cout)
    );

    assign mac_first = (state_q == ST_MAC) && (j_q == '0);

    // Carry fold of the shift phase over the two spare words.
    assign fold_val = {1'b0, acc_q[hi1_idx], acc_q[hi0_idx]} + FW'(carry_q);

    mmm_sub_cell #(.WORD_W(WORD_W)) u_sub (
        .a_w  (acc_q[j_q]),
        .b_w  (n_rd),
        .bin  (borrow_q),
        .diff (sub_diff),
        .bout (sub_bout)
    );

    // Result bank receives the difference words during SUB.
    mmm_opbank #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (state_q == ST_SUB),
        .waddr (j_q[IDX_W-1:0]),
        .wdata (sub_diff),
        .raddr (rd_addr),
        .rdata (res_rd)
    );

    // Negative-inverse register: loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ninv_q <= '0;
        else if (wr_en && idle && wr_sel == 2'd3)  ninv_q <= wr_data;
    end

    // Sequencer and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            len_q      <= '0;
            i_q        <= '0;
            j_q        <= '0;
            sqr_q      <= 1'b0;
            borrow_q   <= 1'b0;
            use_diff_q <= 1'b0;
            done_q     <= 1'b0;
            m_q        <= '0;
            ai_q       <= '0;
            carry_q    <= '0;
            for (int k = 0; k < ACC_D; k++) acc_q[k] <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        len_q      <= len_words;
                        sqr_q      <= sqr_mode;
                        i_q        <= '0;
                        j_q        <= '0;
                        use_diff_q <= 1'b0;
                        for (int k = 0; k < ACC_D; k++) acc_q[k] <= '0;
                        state_q    <= ST_QUOT;
                    end
                end
                ST_QUOT: begin
                    ai_q    <= a_rd;
                    m_q     <= m_next;
                    carry_q <= '0;
                    state_q <= ST_MAC;
                end
                ST_MAC: begin
                    if (j_q != '0) acc_q[j_q - LEN_W'(1)] <= mac_lo;
                    carry_q <= mac_cout;
                    if (j_q == last_idx) begin
                        j_q     <= '0;
                        state_q <= ST_SHIFT;
                    end else begin
                        j_q <= j_q + LEN_W'(1);
                    end
                end
                ST_SHIFT: begin
                    acc_q[last_idx] <= fold_val[WORD_W-1:0];
                    acc_q[hi0_idx]  <= fold_val[2*WORD_W-1:WORD_W];
                    acc_q[hi1_idx]  <= WORD_W'(fold_val[FW-1]);
                    if (i_q == last_idx) begin
                        borrow_q <= 1'b0;
                        state_q  <= ST_SUB;
                    end else begin
                        i_q     <= i_q + LEN_W'(1);
                        state_q <= ST_QUOT;
                    end
                end
                ST_SUB: begin
                    borrow_q <= sub_bout;
                    if (j_q == last_idx) begin
                        use_diff_q <= (acc_q[hi0_idx] != '0) ||
                                      (acc_q[hi1_idx] != '0) || !sub_bout;
                        done_q     <= 1'b1;
                        j_q        <= '0;
                        state_q    <= ST_IDLE;
                    end else begin
                        j_q <= j_q + LEN_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output: reduced copy when the subtraction applied, else the accumulator.
    assign rd_data = use_diff_q ? res_rd : acc_q[rd_addr];
    assign busy    = !idle;
    assign done    = done_q;

endmodule

// File: rtl/mont_mul_fios_chk.sv
// Checker for mont_mul_fios, attached by bind. Observes ports and the
// inner-loop word that the reduction factor is meant to cancel.
module mont_mul_fios_chk #(
    parameter int  WORD_W    = 32,
    parameter int  MIN_WORDS = 4,
    parameter int  MAX_WORDS = 64,
    localparam int LEN_W     = $clog2(MAX_WORDS + 1),
    localparam int IDX_W     = $clog2(MAX_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  len_words,
    input logic              busy,
    input logic              done,
    input logic [IDX_W-1:0]  rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              mac_first,
    input logic [WORD_W-1:0] mac_lo
);

    // R1: the reduction factor makes the lowest word of each sweep vanish.
    a_r1_low_word_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        mac_first |-> (mac_lo == '0));

    // R2: an accepted length lies in the supported range.
    a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (len_words >= LEN_W'(MIN_WORDS) &&
                              len_words <= LEN_W'(MAX_WORDS)));

    // R5: an accepted start makes the block busy.
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: done lasts one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done is raised only once the block is idle.
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: while idle with no start, the word at a fixed address holds.
    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (rd_addr != $past(rd_addr)) ||
                              (rd_data == $past(rd_data)));

endmodule

bind mont_mul_fios mont_mul_fios_chk #(
    .WORD_W    (WORD_W),
    .MIN_WORDS (MIN_WORDS),
    .MAX_WORDS (MAX_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len_words (len_words),
    .busy      (busy),
    .done      (done),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .mac_first (mac_first),
    .mac_lo    (mac_lo)
);

// File: tb/mont_mul_fios_tb.sv
// Self-checking bench: seeded random operands plus directed corner cases,
// compared with a full-product-then-reduce reference model.
module mont_mul_fios_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MW         = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sqr_mode = 1'b0;
    logic [6:0]  len_words = 7'd4;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] ta [MW];
    logic [31:0] tb [MW];
    logic [31:0] tn [MW];
    logic [31:0] texp [MW];
    logic [31:0] np;

    always #(CLK_PERIOD/2) clk = ~clk;

    mont_mul_fios u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sqr_mode  (sqr_mode),
        .len_words (len_words),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual %h expected %h", 0, 1);
        summary();
        $finish;
    end

    // -N^-1 mod 2^32 by Newton iteration.
    function automatic logic [31:0] calc_ninv(input logic [31:0] n0);
        logic [31:0] x = 32'd1;
        for (int k = 0; k < 5; k++) x = x * (32'd2 - n0 * x);
        return -x;
    endfunction

    // Reference: full product, then word-wise reduction, then one subtract.
    task automatic ref_calc(input int s, input bit sq);
        logic [31:0] p [2*MW+2];
        logic [63:0] t, c;
        logic [31:0] m, bw;
        logic [31:0] r [MW+1];
        bit ge;
        for (int k = 0; k < 2*MW+2; k++) p[k] = '0;
        for (int i = 0; i < s; i++) begin
            c = '0;
            for (int j = 0; j < s; j++) begin
                bw = sq ? ta[j] : tb[j];
                t = 64'(p[i+j]) + 64'(ta[i]) * 64'(bw) + c;
                p[i+j] = t[31:0];
                c = {32'd0, t[63:32]};
            end
            p[i+s] = c[31:0];
        end
        for (int i = 0; i < s; i++) begin
            m = p[i] * np;
            c = '0;
            for (int j = 0; j < s; j++) begin
                t = 64'(p[i+j]) + 64'(m) * 64'(tn[j]) + c;
                p[i+j] = t[31:0];
                c = {32'd0, t[63:32]};
            end
            for (int k = i + s; k < 2*MW+2; k++) begin
                t = 64'(p[k]) + c;
                p[k] = t[31:0];
                c = {32'd0, t[63:32]};
            end
        end
        for (int w = 0; w <= s; w++) r[w] = p[s+w];
        ge = 1'b1;
        if (r[s] == '0) begin
            for (int w = s - 1; w >= 0; w--) begin
                if (r[w] != tn[w]) begin
                    ge = (r[w] > tn[w]);
                    break;
                end
            end
        end
        c = '0;
        for (int w = 0; w < s; w++) begin
            if (ge) begin
                t = 64'(r[w]) - 64'(tn[w]) - c;
                texp[w] = t[31:0];
                c = {63'd0, t[63]};
            end else begin
                texp[w] = r[w];
            end
        end
    endtask

    task automatic gen_mod(input int s);
        for (int w = 0; w < MW; w++) tn[w] = $urandom;
        tn[0] = tn[0] | 32'd1;
        tn[s-1] = tn[s-1] | 32'h8000_0000;
        np = calc_ninv(tn[0]);
    endtask

    // Random operand below N; words from s upward are unrelated filler.
    task automatic gen_op(input bit to_b, input int s);
        logic [31:0] v;
        for (int w = 0; w < MW; w++) begin
            v = $urandom;
            if (w == s - 1) v = $urandom % tn[s-1];
            if (to_b) tb[w] = v; else ta[w] = v;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_addr = 6'(addr);
        wr_data = d;
    endtask

    task automatic wr_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_bank(input int sel);
        for (int w = 0; w < MW; w++) begin
            if (sel == 0) wr(2'd0, w, ta[w]);
            else if (sel == 1) wr(2'd1, w, tb[w]);
            else wr(2'd2, w, tn[w]);
        end
        wr_end();
    endtask

    task automatic load_all();
        load_bank(0);
        load_bank(1);
        load_bank(2);
        wr(2'd3, 0, np);
        wr_end();
    endtask

    task automatic read_result(input int s, input string req);
        int bad = -1;
        logic [31:0] got = '0;
        for (int w = 0; w < s; w++) begin
            @(negedge clk);
            rd_addr = 6'(w);
            #1;
            if (rd_data !== texp[w] && bad < 0) begin
                bad = w;
                got = rd_data;
            end
        end
        if (bad < 0) chk(1'b1, req, "result", '0, '0);
        else chk(1'b0, req, $sformatf("result word %0d", bad), got, texp[bad]);
    endtask

    // Run one operation; disturb pulses a write and a start mid-run (R7).
    task automatic run_op(input int s, input bit sq, input string req, input bit disturb);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        sqr_mode = sq;
        len_words = 7'(s);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R5", "busy after start", 32'(busy), 1);
        cnt = 0;
        while (cnt < 20000) begin
            @(negedge clk);
            cnt++;
            if (done === 1'b1) break;
            if (disturb && cnt == 2) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_addr = '0; wr_data = ~ta[0];
                start = 1'b1; sqr_mode = ~sq; len_words = 7'd4;
            end
            if (disturb && cnt == 3) begin
                wr_en = 1'b0; start = 1'b0; sqr_mode = sq; len_words = 7'(s);
            end
        end
        chk(cnt == s*s + 3*s, "R5", "done latency", 32'(cnt), 32'(s*s + 3*s));
        chk(busy === 1'b0, "R5", "busy low at done", 32'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R5", "done single cycle", 32'(done), 0);
        read_result(s, req);
    endtask

    initial begin
        int lens [6] = '{4, 5, 8, 13, 16, 64};
        int slen [3] = '{4, 9, 64};
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R8", "busy in reset", 32'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(busy === 1'b0, "R8", "busy after reset", 32'(busy), 0);
        chk(done === 1'b0, "R8", "done after reset", 32'(done), 0);
        chk(rd_data === 32'd0, "R8", "rd_data after reset", rd_data, 0);

        // R1 directed: zero operand gives zero.
        gen_mod(4);
        gen_op(1'b1, 4);
        for (int w = 0; w < MW; w++) ta[w] = (w < 4) ? 32'd0 : $urandom;
        for (int w = 0; w < MW; w++) texp[w] = '0;
        load_all();
        run_op(4, 1'b0, "R1 zero", 1'b0);

        // R1 directed: Montgomery one (R - N) times B returns B.
        gen_mod(4);
        gen_op(1'b1, 4);
        for (int w = 0; w < MW; w++) ta[w] = (w < 4) ? ~tn[w] : $urandom;
        ta[0] = ta[0] + 32'd1;
        for (int w = 0; w < MW; w++) texp[w] = tb[w];
        load_all();
        run_op(4, 1'b0, "R1 one", 1'b0);

        // R1 and R2: random operands over several lengths, filler above s.
        foreach (lens[k]) begin
            gen_mod(lens[k]);
            gen_op(1'b0, lens[k]);
            gen_op(1'b1, lens[k]);
            ref_calc(lens[k], 1'b0);
            load_all();
            run_op(lens[k], 1'b0, "R1/R2 random", 1'b0);
        end

        // R1 corner: both operands N-1.
        gen_mod(6);
        for (int w = 0; w < MW; w++) begin ta[w] = tn[w]; tb[w] = tn[w]; end
        ta[0] = tn[0] - 32'd1;
        tb[0] = tn[0] - 32'd1;
        ref_calc(6, 1'b0);
        load_all();
        run_op(6, 1'b0, "R1 max", 1'b0);

        // R4: squaring with an unrelated B bank.
        foreach (slen[k]) begin
            gen_mod(slen[k]);
            gen_op(1'b0, slen[k]);
            for (int w = 0; w < MW; w++) tb[w] = $urandom;
            ref_calc(slen[k], 1'b1);
            load_all();
            run_op(slen[k], 1'b1, "R4 square", 1'b0);
        end

        // R3: new A only; n' is not rewritten.
        gen_mod(8);
        gen_op(1'b0, 8);
        gen_op(1'b1, 8);
        ref_calc(8, 1'b0);
        load_all();
        run_op(8, 1'b0, "R3 first", 1'b0);
        gen_op(1'b0, 8);
        ref_calc(8, 1'b0);
        load_bank(0);
        run_op(8, 1'b0, "R3 held inverse", 1'b0);

        // R7: write and start during busy are ignored; bank A unchanged after.
        gen_mod(8);
        gen_op(1'b0, 8);
        gen_op(1'b1, 8);
        ref_calc(8, 1'b0);
        load_all();
        run_op(8, 1'b0, "R7 disturbed", 1'b1);
        run_op(8, 1'b0, "R7 bank intact", 1'b0);

        // R6: result holds through later operand writes and idle cycles.
        for (int w = 0; w < MW; w++) tb[w] = $urandom;
        load_bank(1);
        repeat (20) @(negedge clk);
        read_result(8, "R6 held");

        summary();
        $finish;
    end

endmodule